// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between a CPU's 16-bit address bus and the memories of a small handheld system. From the address, the access direction and a handful of mode and status inputs, it decides in the same cycle which memory, if any, receives the access. It reports that choice as a one-hot target select, the offset of the access inside the chosen memory, and a per-target write enable. On reads it steers the chosen memory's data back to the CPU. Where no target answers, the read data is forced to 0xFF.

The map covers a boot ROM overlay with an extra window in color mode, cartridge space, banked video RAM, fixed and banked work RAM with a mirror, attribute memory, I/O registers and a small high RAM. The video and attribute areas open only when the pixel engine grants access. While an attribute DMA is running, the visible map shrinks to a few regions. The memories, the cartridge mapper and the register contents are outside this block.

Top module: `sysBusDecoder`

## Requirements
- R1: Addresses 0x0000–0x00FF select the boot ROM (tgtSel bit 0) while bootOff is 0, and the cartridge (tgtSel bit 1) while bootOff is 1. The offset equals the address.
- R2: Addresses 0x0200–0x08FF select the boot ROM only when colorMode is 1 and bootOff is 0, and the cartridge otherwise. Addresses 0x0100–0x01FF and 0x0900–0x7FFF always select the cartridge.
- R3: Addresses 0xA000–0xBFFF and all cartridge accesses select the cartridge with the offset equal to the address. Cartridge writes raise wrEn bit 1.
- R4: A write whose address falls in the boot ROM overlay selects nothing and raises no write enable.
- R5: Addresses 0x8000–0x9FFF select video RAM (tgtSel bit 2) with offset vramBank×0x2000 + addr[12:0], only if ppuVramRd (for reads) or ppuVramWr (for writes) is 1. Otherwise nothing is selected and a read returns 0xFF.
- R6: Work RAM (tgtSel bit 3) is selected as follows. 0xC000–0xCFFF uses offset addr[11:0]. 0xD000–0xDFFF uses wramBank×0x1000 + addr[11:0]. 0xE000–0xEFFF and 0xF000–0xFDFF repeat these two mappings.
- R7: Addresses 0xFE00–0xFE9F select attribute memory (tgtSel bit 4) with offset addr[7:0], gated by ppuOamRd or ppuOamWr. Addresses 0xFEA0–0xFEFF select nothing, read 0xFF and write nothing.
- R8: Addresses 0xFF00–0xFF7F and 0xFFFF select the I/O registers (tgtSel bit 5) with offset addr[7:0]. Addresses 0xFF80–0xFFFE select high RAM (tgtSel bit 6) with offset addr − 0xFF80.
- R9: While dmaBusy is 1, only these regions answer: 0xE000–0xFDFF (work RAM as in R6), the I/O registers, and high RAM. Attribute memory answers only when dmaOamGrant is 1, regardless of the pixel-engine grants. Every other access selects nothing and reads 0xFF.
- R10: While dmaBusy is 1, a read below 0x8000 selects the cartridge (never the boot ROM) only if dmaSrcPage ≥ 0x80, and otherwise returns 0xFF. Writes below 0x8000 select nothing.
- R11: At most one tgtSel bit is set. wrEn equals tgtSel on writes and is zero on reads. rdData equals the selected target's read data, or 0xFF when nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busAddr | input | 16 | CPU bus address |
| busWr | input | 1 | 1 = write access, 0 = read access |
| bootOff | input | 1 | Boot ROM disabled (bit 0 of the boot control register) |
| colorMode | input | 1 | Color mode, enables the extended boot window |
| vramBank | input | 1 | Video RAM bank number |
| wramBank | input | 3 | Work RAM bank number for the switchable half |
| ppuVramRd | input | 1 | Pixel engine allows video RAM reads |
| ppuVramWr | input | 1 | Pixel engine allows video RAM writes |
| ppuOamRd | input | 1 | Pixel engine allows attribute reads |
| ppuOamWr | input | 1 | Pixel engine allows attribute writes |
| dmaBusy | input | 1 | Attribute DMA in progress |
| dmaOamGrant | input | 1 | Attribute memory reachable during DMA |
| dmaSrcPage | input | 8 | High byte of the DMA source address |
| bootRdData | input | 8 | Boot ROM read data |
| cartRdData | input | 8 | Cartridge read data |
| vramRdData | input | 8 | Video RAM read data |
| wramRdData | input | 8 | Work RAM read data |
| oamRdData | input | 8 | Attribute memory read data |
| ioRdData | input | 8 | I/O register read data |
| hramRdData | input | 8 | High RAM read data |
| tgtSel | output | 7 | One-hot target: 0 boot, 1 cart, 2 vram, 3 wram, 4 oam, 5 io, 6 hram |
| tgtOffset | output | 16 | Offset inside the selected target (0 when none) |
| wrEn | output | 7 | Per-target write enable, same bit order as tgtSel |
| rdData | output | 8 | Read data returned to the CPU |

## Verification
Every output is purely combinational, so each result is due in the same time step as the stimulus that causes it, with zero cycles of latency. The bench drives inputs just after a falling clock edge. It waits one nanosecond so the logic can settle, then samples select, offset, write enables and read data, well away from the next rising edge. Each memory's read data input carries a distinct constant, so the value on rdData shows which path the steering took. Mode and grant inputs are changed only between vectors, never while a check is being sampled.

// File: rtl/sysBusDecoderPkg.sv
package sysBusDecoderPkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int NUM_TGT = 7;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_BOOT = 3'd1,
    TGT_CART = 3'd2,
    TGT_VRAM = 3'd3,
    TGT_WRAM = 3'd4,
    TGT_OAM  = 3'd5,
    TGT_IO   = 3'd6,
    TGT_HRAM = 3'd7
  } target_e;

  typedef enum logic [3:0] {
    RG_BOOTLOW, RG_HDR, RG_BOOTEXT, RG_ROM, RG_VRAM, RG_XRAM,
    RG_WRAM0, RG_WRAMB, RG_ECHO0, RG_ECHOB, RG_OAM, RG_HOLE,
    RG_IO, RG_HRAM, RG_IE
  } region_e;

  typedef struct packed {
    target_e tgt;
    logic    bankedHalf;
  } ctrlStrobes_t;
endpackage

// File: rtl/sysBusRegion.sv
module sysBusRegion
  import sysBusDecoderPkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  output region_e           region
);
  always_comb begin
    if (busAddr < 16'h0100)       region = RG_BOOTLOW;
    else if (busAddr < 16'h0200)  region = RG_HDR;
    else if (busAddr < 16'h0900)  region = RG_BOOTEXT;
    else if (busAddr < 16'h8000)  region = RG_ROM;
    else if (busAddr < 16'hA000)  region = RG_VRAM;
    else if (busAddr < 16'hC000)  region = RG_XRAM;
    else if (busAddr < 16'hD000)  region = RG_WRAM0;
    else if (busAddr < 16'hE000)  region = RG_WRAMB;
    else if (busAddr < 16'hF000)  region = RG_ECHO0;
    else if (busAddr < 16'hFE00)  region = RG_ECHOB;
    else if (busAddr < 16'hFEA0)  region = RG_OAM;
    else if (busAddr < 16'hFF00)  region = RG_HOLE;
    else if (busAddr < 16'hFF80)  region = RG_IO;
    else if (busAddr != 16'hFFFF) region = RG_HRAM;
    else                          region = RG_IE;
  end
endmodule

// File: rtl/sysBusCtrl.sv
module sysBusCtrl
  import sysBusDecoderPkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  region_e           region,
  input  logic              busWr,
  input  logic              bootOff,
  input  logic              colorMode,
  input  logic              ppuVramRd,
  input  logic              ppuVramWr,
  input  logic              ppuOamRd,
  input  logic              ppuOamWr,
  input  logic              dmaBusy,
  input  logic              dmaOamGrant,
  input  logic [PAGE_W-1:0] dmaSrcPage,
  output ctrlStrobes_t      strobes
);
  localparam logic [PAGE_W-1:0] CART_PAGE_MIN = PAGE_W'(1) << (PAGE_W - 1);

  logic    vramOpen, oamOpen, bootRead, cartInDma;
  target_e tgt;

  assign vramOpen  = busWr ? ppuVramWr : ppuVramRd;
  assign oamOpen   = busWr ? ppuOamWr : ppuOamRd;
  assign bootRead  = !busWr;
  assign cartInDma = !busWr && (dmaSrcPage >= CART_PAGE_MIN);

  always_comb begin
    tgt = TGT_NONE;
    if (!dmaBusy) begin
      unique case (region)
        RG_BOOTLOW: tgt = bootOff ? TGT_CART : (bootRead ? TGT_BOOT : TGT_NONE);
        RG_BOOTEXT: tgt = (colorMode && !bootOff) ?
                          (bootRead ? TGT_BOOT : TGT_NONE) : TGT_CART;
        RG_HDR, RG_ROM, RG_XRAM: tgt = TGT_CART;
        RG_VRAM:    tgt = vramOpen ? TGT_VRAM : TGT_NONE;
        RG_WRAM0, RG_WRAMB, RG_ECHO0, RG_ECHOB: tgt = TGT_WRAM;
        RG_OAM:     tgt = oamOpen ? TGT_OAM : TGT_NONE;
        RG_IO, RG_IE: tgt = TGT_IO;
        RG_HRAM:    tgt = TGT_HRAM;
        default:    tgt = TGT_NONE;
      endcase
    end else begin
      unique case (region)
        RG_BOOTLOW, RG_HDR, RG_BOOTEXT, RG_ROM:
                    tgt = cartInDma ? TGT_CART : TGT_NONE;
        RG_ECHO0, RG_ECHOB: tgt = TGT_WRAM;
        RG_OAM:     tgt = dmaOamGrant ? TGT_OAM : TGT_NONE;
        RG_IO, RG_IE: tgt = TGT_IO;
        RG_HRAM:    tgt = TGT_HRAM;
        default:    tgt = TGT_NONE;
      endcase
    end
  end

  assign strobes.tgt        = tgt;
  assign strobes.bankedHalf = (region == RG_WRAMB) || (region == RG_ECHOB);
endmodule

// File: rtl/sysBusData.sv
module sysBusData
  import sysBusDecoderPkg::*;
#(
  parameter int VRAM_BANK_W = 1,
  parameter int WRAM_BANK_W = 3
) (
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWr,
  input  logic [VRAM_BANK_W-1:0] vramBank,
  input  logic [WRAM_BANK_W-1:0] wramBank,
  input  ctrlStrobes_t           strobes,
  input  logic [DATA_W-1:0]      rdVec [NUM_TGT],
  output logic [NUM_TGT-1:0]     tgtSel,
  output logic [ADDR_W-1:0]      tgtOffset,
  output logic [NUM_TGT-1:0]     wrEn,
  output logic [DATA_W-1:0]      rdData
);
  localparam int VRAM_PAGE_SH = 13;
  localparam int WRAM_PAGE_SH = 12;

  logic [ADDR_W-1:0] vramOfs, wramOfs;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
    assign tgtSel[i] = (strobes.tgt == target_e'(i + 1));
    assign wrEn[i]   = tgtSel[i] && busWr;
  end

  assign vramOfs = (ADDR_W'(vramBank) << VRAM_PAGE_SH)
                 | ADDR_W'(busAddr[VRAM_PAGE_SH-1:0]);
  assign wramOfs = (strobes.bankedHalf ? (ADDR_W'(wramBank) << WRAM_PAGE_SH) : '0)
                 | ADDR_W'(busAddr[WRAM_PAGE_SH-1:0]);

  always_comb begin
    unique case (strobes.tgt)
      TGT_BOOT, TGT_CART: tgtOffset = busAddr;
      TGT_VRAM:           tgtOffset = vramOfs;
      TGT_WRAM:           tgtOffset = wramOfs;
      TGT_OAM, TGT_IO:    tgtOffset = ADDR_W'(busAddr[7:0]);
      TGT_HRAM:           tgtOffset = ADDR_W'(busAddr[6:0]);
      default:            tgtOffset = '0;
    endcase
  end

  always_comb begin
    rdData = '1;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (tgtSel[i]) rdData = rdVec[i];
    end
  end
endmodule

// File: rtl/sysBusDecoder.sv
module sysBusDecoder
  import sysBusDecoderPkg::*;
#(
  parameter int VRAM_BANK_W = 1,
  parameter int WRAM_BANK_W = 3,
  parameter int PAGE_W      = 8
) (
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWr,
  input  logic                   bootOff,
  input  logic                   colorMode,
  input  logic [VRAM_BANK_W-1:0] vramBank,
  input  logic [WRAM_BANK_W-1:0] wramBank,
  input  logic                   ppuVramRd,
  input  logic                   ppuVramWr,
  input  logic                   ppuOamRd,
  input  logic                   ppuOamWr,
  input  logic                   dmaBusy,
  input  logic                   dmaOamGrant,
  input  logic [PAGE_W-1:0]      dmaSrcPage,
  input  logic [DATA_W-1:0]      bootRdData,
  input  logic [DATA_W-1:0]      cartRdData,
  input  logic [DATA_W-1:0]      vramRdData,
  input  logic [DATA_W-1:0]      wramRdData,
  input  logic [DATA_W-1:0]      oamRdData,
  input  logic [DATA_W-1:0]      ioRdData,
  input  logic [DATA_W-1:0]      hramRdData,
  output logic [NUM_TGT-1:0]     tgtSel,
  output logic [ADDR_W-1:0]      tgtOffset,
  output logic [NUM_TGT-1:0]     wrEn,
  output logic [DATA_W-1:0]      rdData
);
  region_e      region;
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] rdVec [NUM_TGT];

  assign rdVec[0] = bootRdData;
  assign rdVec[1] = cartRdData;
  assign rdVec[2] = vramRdData;
  assign rdVec[3] = wramRdData;
  assign rdVec[4] = oamRdData;
  assign rdVec[5] = ioRdData;
  assign rdVec[6] = hramRdData;

  sysBusRegion regionI (.busAddr(busAddr), .region(region));

  sysBusCtrl #(.PAGE_W(PAGE_W)) ctrlI (
    .region(region), .busWr(busWr), .bootOff(bootOff), .colorMode(colorMode),
    .ppuVramRd(ppuVramRd), .ppuVramWr(ppuVramWr),
    .ppuOamRd(ppuOamRd), .ppuOamWr(ppuOamWr),
    .dmaBusy(dmaBusy), .dmaOamGrant(dmaOamGrant), .dmaSrcPage(dmaSrcPage),
    .strobes(strobes)
  );

  sysBusData #(.VRAM_BANK_W(VRAM_BANK_W), .WRAM_BANK_W(WRAM_BANK_W)) dataI (
    .busAddr(busAddr), .busWr(busWr), .vramBank(vramBank), .wramBank(wramBank),
    .strobes(strobes), .rdVec(rdVec),
    .tgtSel(tgtSel), .tgtOffset(tgtOffset), .wrEn(wrEn), .rdData(rdData)
  );
endmodule

// File: rtl/sysBusDecoderChk.sv
module sysBusDecoderChk
  import sysBusDecoderPkg::*;
(
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic               dmaBusy,
  input logic [7:0]         dmaSrcPage,
  input logic               ppuVramRd,
  input logic               ppuVramWr,
  input logic [NUM_TGT-1:0] tgtSel,
  input logic [NUM_TGT-1:0] wrEn,
  input logic [DATA_W-1:0]  rdData
);
  always_comb begin
    a_r11_one_target: assert ($onehot0(tgtSel))
      else $error("R11 more than one target selected");
    a_r11_wr_follows_sel: assert (wrEn == (busWr ? tgtSel : '0))
      else $error("R11 write enable disagrees with select");
    a_r11_idle_reads_ff: assert (busWr || tgtSel != '0 || rdData == '1)
      else $error("R11 unselected read not 0xFF");
    a_r4_no_boot_write: assert (!(busWr && tgtSel[0]))
      else $error("R4 boot ROM selected on write");
    a_r5_vram_gated: assert (!tgtSel[2] || (busWr ? ppuVramWr : ppuVramRd))
      else $error("R5 video RAM selected without grant");
    a_r7_hole_unmapped: assert (!(busAddr >= 16'hFEA0 && busAddr < 16'hFF00) || tgtSel == '0)
      else $error("R7 unmapped hole selected");
    a_r9_dma_no_vram_boot: assert (!dmaBusy || (!tgtSel[2] && !tgtSel[0]))
      else $error("R9 video RAM or boot ROM reachable during DMA");
    a_r10_dma_low_page: assert (!(dmaBusy && busAddr < 16'h8000 && dmaSrcPage < 8'h80) || tgtSel == '0)
      else $error("R10 cartridge reachable with low DMA page");
  end
endmodule

bind sysBusDecoder sysBusDecoderChk chkI (
  .busAddr(busAddr), .busWr(busWr), .dmaBusy(dmaBusy), .dmaSrcPage(dmaSrcPage),
  .ppuVramRd(ppuVramRd), .ppuVramWr(ppuVramWr),
  .tgtSel(tgtSel), .wrEn(wrEn), .rdData(rdData)
);

// File: tb/sysBusDecoder_tb_top.sv
module sysBusDecoder_tb_top;
  localparam logic [6:0] S_NONE = 7'h00, S_BOOT = 7'h01, S_CART = 7'h02,
    S_VRAM = 7'h04, S_WRAM = 7'h08, S_OAM = 7'h10, S_IO = 7'h20, S_HRAM = 7'h40;
  localparam logic [7:0] D_BOOT = 8'hB0, D_CART = 8'hCA, D_VRAM = 8'h5A,
    D_WRAM = 8'h3C, D_OAM = 8'h0A, D_IO = 8'h10, D_HRAM = 8'h77;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] busAddr = '0;
  logic busWr = 0, bootOff = 0, colorMode = 0;
  logic [0:0] vramBank = '0;
  logic [2:0] wramBank = 3'd1;
  logic ppuVramRd = 1, ppuVramWr = 1, ppuOamRd = 1, ppuOamWr = 1;
  logic dmaBusy = 0, dmaOamGrant = 0;
  logic [7:0] dmaSrcPage = '0;
  logic [6:0] tgtSel, wrEn;
  logic [15:0] tgtOffset;
  logic [7:0] rdData;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  sysBusDecoder dut_i (
    .busAddr(busAddr), .busWr(busWr), .bootOff(bootOff), .colorMode(colorMode),
    .vramBank(vramBank), .wramBank(wramBank),
    .ppuVramRd(ppuVramRd), .ppuVramWr(ppuVramWr), .ppuOamRd(ppuOamRd), .ppuOamWr(ppuOamWr),
    .dmaBusy(dmaBusy), .dmaOamGrant(dmaOamGrant), .dmaSrcPage(dmaSrcPage),
    .bootRdData(D_BOOT), .cartRdData(D_CART), .vramRdData(D_VRAM), .wramRdData(D_WRAM),
    .oamRdData(D_OAM), .ioRdData(D_IO), .hramRdData(D_HRAM),
    .tgtSel(tgtSel), .tgtOffset(tgtOffset), .wrEn(wrEn), .rdData(rdData)
  );

  task automatic access(input string req, input logic [15:0] a, input logic wr,
                        input logic [6:0] expSel, input logic [15:0] expOfs,
                        input logic [7:0] expRd);
    @(negedge clk);
    busAddr = a;
    busWr   = wr;
    #1;
    nChecks++;
    if (tgtSel !== expSel || tgtOffset !== expOfs ||
        wrEn !== (wr ? expSel : 7'h00) || (!wr && rdData !== expRd)) begin
      nFails++;
      $display("FAIL %s addr=%h wr=%0b: sel=%h ofs=%h we=%h rd=%h, expected sel=%h ofs=%h we=%h rd=%h",
               req, a, wr, tgtSel, tgtOffset, wrEn, rdData,
               expSel, expOfs, wr ? expSel : 7'h00, expRd);
    end
  endtask

  task automatic t_reset_state;
    access("R1", 16'h0000, 0, S_BOOT, 16'h0000, D_BOOT);
  endtask

  task automatic t_r1_overlay;
    access("R1", 16'h00FF, 0, S_BOOT, 16'h00FF, D_BOOT);
    bootOff = 1;
    access("R1", 16'h0050, 0, S_CART, 16'h0050, D_CART);
    bootOff = 0;
  endtask

  task automatic t_r2_color_window;
    access("R2", 16'h0150, 0, S_CART, 16'h0150, D_CART);
    access("R2", 16'h0300, 0, S_CART, 16'h0300, D_CART);
    colorMode = 1;
    access("R2", 16'h0300, 0, S_BOOT, 16'h0300, D_BOOT);
    access("R2", 16'h08FF, 0, S_BOOT, 16'h08FF, D_BOOT);
    access("R2", 16'h0900, 0, S_CART, 16'h0900, D_CART);
    access("R2", 16'h0150, 0, S_CART, 16'h0150, D_CART);
    bootOff = 1;
    access("R2", 16'h0300, 0, S_CART, 16'h0300, D_CART);
    bootOff = 0; colorMode = 0;
  endtask

  task automatic t_r3_cart;
    access("R3", 16'h4000, 0, S_CART, 16'h4000, D_CART);
    access("R3", 16'hA123, 0, S_CART, 16'hA123, D_CART);
    access("R3", 16'hB000, 1, S_CART, 16'hB000, 8'h00);
  endtask

  task automatic t_r4_boot_write;
    access("R4", 16'h0010, 1, S_NONE, 16'h0000, 8'h00);
    colorMode = 1;
    access("R4", 16'h0400, 1, S_NONE, 16'h0000, 8'h00);
    access("R4", 16'h0010, 0, S_BOOT, 16'h0010, D_BOOT);
    colorMode = 0;
  endtask

  task automatic t_r5_vram;
    vramBank = 1'b1;
    access("R5", 16'h8010, 0, S_VRAM, 16'h2010, D_VRAM);
    ppuVramRd = 0;
    access("R5", 16'h9000, 0, S_NONE, 16'h0000, 8'hFF);
    vramBank = 1'b0;
    access("R5", 16'h9FFF, 1, S_VRAM, 16'h1FFF, 8'h00);
    ppuVramWr = 0;
    access("R5", 16'h9FFF, 1, S_NONE, 16'h0000, 8'h00);
    ppuVramRd = 1; ppuVramWr = 1;
  endtask

  task automatic t_r6_wram;
    wramBank = 3'd3;
    access("R6", 16'hC005, 0, S_WRAM, 16'h0005, D_WRAM);
    access("R6", 16'hD005, 0, S_WRAM, 16'h3005, D_WRAM);
    access("R6", 16'hE005, 0, S_WRAM, 16'h0005, D_WRAM);
    access("R6", 16'hF005, 0, S_WRAM, 16'h3005, D_WRAM);
    access("R6", 16'hFDFF, 0, S_WRAM, 16'h3DFF, D_WRAM);
    access("R6", 16'hD100, 1, S_WRAM, 16'h3100, 8'h00);
    wramBank = 3'd1;
  endtask

  task automatic t_r7_oam_hole;
    access("R7", 16'hFE9F, 0, S_OAM, 16'h009F, D_OAM);
    ppuOamRd = 0;
    access("R7", 16'hFE00, 0, S_NONE, 16'h0000, 8'hFF);
    ppuOamRd = 1; ppuOamWr = 0;
    access("R7", 16'hFE20, 1, S_NONE, 16'h0000, 8'h00);
    ppuOamWr = 1;
    access("R7", 16'hFEA0, 0, S_NONE, 16'h0000, 8'hFF);
    access("R7", 16'hFEFF, 1, S_NONE, 16'h0000, 8'h00);
  endtask

  task automatic t_r8_io_hram;
    access("R8", 16'hFF00, 0, S_IO, 16'h0000, D_IO);
    access("R8", 16'hFF7F, 0, S_IO, 16'h007F, D_IO);
    access("R8", 16'hFF80, 0, S_HRAM, 16'h0000, D_HRAM);
    access("R8", 16'hFFFE, 0, S_HRAM, 16'h007E, D_HRAM);
    access("R8", 16'hFFFF, 0, S_IO, 16'h00FF, D_IO);
    access("R8", 16'hFF90, 1, S_HRAM, 16'h0010, 8'h00);
  endtask

  task automatic t_r9_dma_map;
    dmaBusy = 1; wramBank = 3'd2;
    access("R9", 16'hC000, 0, S_NONE, 16'h0000, 8'hFF);
    access("R9", 16'hD000, 0, S_NONE, 16'h0000, 8'hFF);
    access("R9", 16'hE010, 0, S_WRAM, 16'h0010, D_WRAM);
    access("R9", 16'hF010, 0, S_WRAM, 16'h2010, D_WRAM);
    access("R9", 16'h8000, 0, S_NONE, 16'h0000, 8'hFF);
    access("R9", 16'hFE10, 0, S_NONE, 16'h0000, 8'hFF);
    dmaOamGrant = 1; ppuOamRd = 0;
    access("R9", 16'hFE10, 0, S_OAM, 16'h0010, D_OAM);
    ppuOamRd = 1; dmaOamGrant = 0;
    access("R9", 16'hFF05, 0, S_IO, 16'h0005, D_IO);
    access("R9", 16'hFF90, 0, S_HRAM, 16'h0010, D_HRAM);
    access("R9", 16'hFEB0, 0, S_NONE, 16'h0000, 8'hFF);
    dmaBusy = 0; wramBank = 3'd1;
  endtask

  task automatic t_r10_dma_low;
    dmaBusy = 1; dmaSrcPage = 8'h7F;
    access("R10", 16'h1234, 0, S_NONE, 16'h0000, 8'hFF);
    dmaSrcPage = 8'h80;
    access("R10", 16'h1234, 0, S_CART, 16'h1234, D_CART);
    access("R10", 16'h0010, 0, S_CART, 16'h0010, D_CART);
    access("R10", 16'h2000, 1, S_NONE, 16'h0000, 8'h00);
    dmaBusy = 0; dmaSrcPage = 8'h00;
  endtask

  initial begin
    t_reset_state();
    t_r1_overlay();
    t_r2_color_window();
    t_r3_cart();
    t_r4_boot_write();
    t_r5_vram();
    t_r6_wram();
    t_r7_oam_hole();
    t_r8_io_hram();
    t_r9_dma_map();
    t_r10_dma_low();
    // R11 is covered by every vector: one-hot select, wrEn vs busWr, 0xFF when idle
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule